// File: doc/BRIEF.md
# Multi-Entry Destination Address Filter

This block decides whether an incoming Ethernet frame should be kept by looking only at its 48-bit destination address. Ten exact-match station addresses are held in a linear byte store. Software writes that store one byte at a time, using an index from 0 to 59. Entry `e` owns indices `6e` through `6e+5`, so on a system that pages the store in groups of eight bytes, an entry can span two pages. A four-bit mode word selects:

- individual-address filtering,
- accept-all-multicast,
- promiscuous reception of non-multicast frames,
- rejection of broadcast frames.

A hash-hit input comes from a separate multicast hash block.

The destination address arrives one byte per accepted cycle, first byte first. A start strobe marks the first byte. Each byte is compared against the matching byte of every entry as it arrives, so no address register is needed. The verdict appears in the cycle after the sixth byte and stays until the next frame starts. The verdict holds accept, broadcast, multicast and address-match flags.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset, `flt_done`, `flt_accept`, `flt_bcast`, `flt_mcast` and `flt_match` are 0 and all 60 stored bytes are 0. All four flags are 0 whenever `flt_done` is 0.
- R2: With `mode[0]`=1, a destination equal to any of the ten entries sets `flt_match`=1 and `flt_accept`=1.
- R3: Entry 0 takes part in matching even when `mode[0]`=0. Entries 1 to 9 do not match while `mode[0]`=0.
- R4: A write with `cfg_we`=1 stores `cfg_wdata` at byte `cfg_idx mod 6` of entry `cfg_idx / 6`. Byte 0 of an entry is compared with the first received destination byte. A write with `cfg_idx` of 60 or above changes no entry.
- R5: A destination of all ones sets `flt_bcast`=1 and `flt_mcast`=0. It is accepted unless `mode[3]`=1, in which case it is refused (absent a match or promiscuous mode).
- R6: A destination whose first byte has bit 0 set and that is not all ones sets `flt_mcast`=1. It is accepted when `mode[1]`=1 or `hash_hit`=1.
- R7: With `mode[2]`=1, every destination with `flt_mcast`=0 is accepted. Multicast destinations are not accepted by this bit.
- R8: `flt_done` and the flags update at the clock edge that samples the sixth byte. They hold until the next byte carrying `da_start`, and that byte clears them at its edge. Idle cycles between bytes are allowed.
- R9: Bytes after the sixth, and `da_valid` bytes with no start since the last verdict, have no effect.
- R10: `mode` and `hash_hit` are sampled only in the cycle of the sixth byte. Later changes do not alter a held verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Address store write strobe |
| cfg_idx | input | 8 | Linear byte index, 0 to 59 |
| cfg_wdata | input | 8 | Byte to store |
| mode | input | 4 | bit0 individual filter enable, bit1 all multicast, bit2 promiscuous, bit3 reject broadcast |
| hash_hit | input | 1 | Multicast hash lookup hit |
| da_valid | input | 1 | Destination byte valid |
| da_start | input | 1 | Marks the first destination byte (only with da_valid) |
| da_byte | input | 8 | Destination byte |
| flt_done | output | 1 | Verdict valid |
| flt_accept | output | 1 | Frame accepted |
| flt_bcast | output | 1 | Destination is broadcast |
| flt_mcast | output | 1 | Destination is multicast (0 means physical) |
| flt_match | output | 1 | Destination equals an enabled entry |

## Verification
The assertions take for granted that `da_start` is raised only together with `da_valid`. They also assume the address store is not rewritten while a destination is being collected, so the entries a verdict was compared against are the ones software intended. The stimulus respects both conditions. Start is driven only on a first byte, and configuration writes, including out-of-range indices, are issued only between frames. Within those limits it varies the gaps between bytes, the mode word, the hash input, trailing extra bytes and starts with no frame open.

// File: rtl/dfl_pkg.sv
package dfl_pkg;
  localparam int BYTE_W = 8;

  localparam int MODE_IA_EN    = 0;
  localparam int MODE_ALL_MC   = 1;
  localparam int MODE_PROMISC  = 2;
  localparam int MODE_BC_REJ   = 3;
  localparam int MODE_W        = 4;

  typedef struct packed {
    logic accept;
    logic bcast;
    logic mcast;
    logic match;
  } dfl_verdict_t;
endpackage

// File: rtl/dfl_entry_store.sv
module dfl_entry_store #(
  parameter int N_ENT   = 10,
  parameter int N_BYTES = 6,
  parameter int IDX_W   = 8,
  localparam int TOTAL  = N_ENT * N_BYTES
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [IDX_W-1:0]                   wr_idx,
  input  logic [dfl_pkg::BYTE_W-1:0]         wr_data,
  output logic [TOTAL*dfl_pkg::BYTE_W-1:0]   store_flat
);
  localparam int BW = dfl_pkg::BYTE_W;

  for (genvar g = 0; g < TOTAL; g++) begin : g_byte
    logic          sel;
    logic [BW-1:0] byte_q;
    logic [BW-1:0] byte_d;

    always_comb begin
      sel    = wr_en && (wr_idx == IDX_W'(g));
      byte_d = sel ? wr_data : byte_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= '0;
      else        byte_q <= byte_d;
    end

    assign store_flat[g*BW +: BW] = byte_q;
  end
endmodule

// File: rtl/dfl_da_collector.sv
module dfl_da_collector #(
  parameter int N_ENT   = 10,
  parameter int N_BYTES = 6,
  localparam int TOTAL  = N_ENT * N_BYTES,
  localparam int POS_W  = (N_BYTES > 1) ? $clog2(N_BYTES) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              da_valid,
  input  logic                              da_start,
  input  logic [dfl_pkg::BYTE_W-1:0]        da_byte,
  input  logic [TOTAL*dfl_pkg::BYTE_W-1:0]  store_flat,
  output logic                              last_byte,
  output logic                              frame_open,
  output logic [N_ENT-1:0]                  hit_nxt,
  output logic                              ones_nxt,
  output logic                              grp_nxt
);
  localparam int BW = dfl_pkg::BYTE_W;

  logic             busy_q, busy_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [N_ENT-1:0] hit_q, hit_d;
  logic             ones_q, ones_d;
  logic             grp_q, grp_d;
  logic             take;
  logic [POS_W-1:0] pos_sel;

  always_comb begin
    take       = da_valid && (da_start || busy_q);
    pos_sel    = da_start ? '0 : pos_q;
    last_byte  = take && (pos_sel == POS_W'(N_BYTES - 1));
    frame_open = da_valid && da_start;
  end

  for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
    logic [BW-1:0] ref_byte;
    always_comb begin
      ref_byte   = store_flat[(e*N_BYTES + int'(pos_sel))*BW +: BW];
      hit_nxt[e] = (da_start ? 1'b1 : hit_q[e]) && (ref_byte == da_byte);
    end
  end

  always_comb begin
    ones_nxt = (da_start ? 1'b1 : ones_q) && (da_byte == {BW{1'b1}});
    grp_nxt  = da_start ? da_byte[0] : grp_q;

    busy_d = busy_q;
    pos_d  = pos_q;
    hit_d  = hit_q;
    ones_d = ones_q;
    grp_d  = grp_q;
    if (take) begin
      busy_d = !last_byte;
      pos_d  = pos_sel + 1'b1;
      hit_d  = hit_nxt;
      ones_d = ones_nxt;
      grp_d  = grp_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
      hit_q  <= '0;
      ones_q <= 1'b0;
      grp_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      pos_q  <= pos_d;
      hit_q  <= hit_d;
      ones_q <= ones_d;
      grp_q  <= grp_d;
    end
  end
endmodule

// File: rtl/dfl_decide.sv
module dfl_decide #(
  parameter int N_ENT = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         last_byte,
  input  logic                         frame_open,
  input  logic [N_ENT-1:0]             hit_nxt,
  input  logic                         ones_nxt,
  input  logic                         grp_nxt,
  input  logic [dfl_pkg::MODE_W-1:0]   mode,
  input  logic                         hash_hit,
  output logic                         done,
  output dfl_pkg::dfl_verdict_t        verdict
);
  import dfl_pkg::*;

  logic [N_ENT-1:0] en_mask;
  dfl_verdict_t     vd_new;
  dfl_verdict_t     vd_q, vd_d;
  logic             done_q, done_d;

  // Entry 0 is always live; the rest follow the individual filter enable.
  for (genvar e = 0; e < N_ENT; e++) begin : g_mask
    if (e == 0) begin : g_always
      assign en_mask[e] = 1'b1;
    end else begin : g_gated
      assign en_mask[e] = mode[MODE_IA_EN];
    end
  end

  always_comb begin
    vd_new.match  = |(hit_nxt & en_mask);
    vd_new.bcast  = ones_nxt;
    vd_new.mcast  = grp_nxt && !ones_nxt;
    vd_new.accept = vd_new.match
                 || (vd_new.bcast && !mode[MODE_BC_REJ])
                 || (vd_new.mcast && (mode[MODE_ALL_MC] || hash_hit))
                 || (!vd_new.mcast && mode[MODE_PROMISC]);

    done_d = done_q;
    vd_d   = vd_q;
    if (last_byte) begin
      done_d = 1'b1;
      vd_d   = vd_new;
    end else if (frame_open) begin
      done_d = 1'b0;
      vd_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      vd_q   <= '0;
    end else begin
      done_q <= done_d;
      vd_q   <= vd_d;
    end
  end

  assign done    = done_q;
  assign verdict = vd_q;
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter #(
  parameter int N_ENT   = 10,
  parameter int N_BYTES = 6,
  parameter int IDX_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [7:0]       cfg_wdata,
  input  logic [3:0]       mode,
  input  logic             hash_hit,
  input  logic             da_valid,
  input  logic             da_start,
  input  logic [7:0]       da_byte,
  output logic             flt_done,
  output logic             flt_accept,
  output logic             flt_bcast,
  output logic             flt_mcast,
  output logic             flt_match
);
  import dfl_pkg::*;

  localparam int TOTAL = N_ENT * N_BYTES;

  logic [TOTAL*BYTE_W-1:0] store_flat;
  logic                    last_byte;
  logic                    frame_open;
  logic [N_ENT-1:0]        hit_nxt;
  logic                    ones_nxt;
  logic                    grp_nxt;
  dfl_verdict_t            verdict;

  dfl_entry_store #(.N_ENT(N_ENT), .N_BYTES(N_BYTES), .IDX_W(IDX_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_we),
    .wr_idx     (cfg_idx),
    .wr_data    (cfg_wdata),
    .store_flat (store_flat)
  );

  dfl_da_collector #(.N_ENT(N_ENT), .N_BYTES(N_BYTES)) u_coll (
    .clk        (clk),
    .rst_n      (rst_n),
    .da_valid   (da_valid),
    .da_start   (da_start),
    .da_byte    (da_byte),
    .store_flat (store_flat),
    .last_byte  (last_byte),
    .frame_open (frame_open),
    .hit_nxt    (hit_nxt),
    .ones_nxt   (ones_nxt),
    .grp_nxt    (grp_nxt)
  );

  dfl_decide #(.N_ENT(N_ENT)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .last_byte  (last_byte),
    .frame_open (frame_open),
    .hit_nxt    (hit_nxt),
    .ones_nxt   (ones_nxt),
    .grp_nxt    (grp_nxt),
    .mode       (mode),
    .hash_hit   (hash_hit),
    .done       (flt_done),
    .verdict    (verdict)
  );

  assign flt_accept = verdict.accept;
  assign flt_bcast  = verdict.bcast;
  assign flt_mcast  = verdict.mcast;
  assign flt_match  = verdict.match;
endmodule

// File: rtl/dfl_checker.sv
module dfl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] mode,
  input logic       da_valid,
  input logic       da_start,
  input logic       flt_done,
  input logic       flt_accept,
  input logic       flt_bcast,
  input logic       flt_mcast,
  input logic       flt_match
);
  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_done |-> !(flt_accept || flt_bcast || flt_mcast || flt_match));

  assert_match_accepts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flt_done && flt_match |-> flt_accept);

  assert_bc_mc_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flt_done |-> !(flt_bcast && flt_mcast));

  assert_bc_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_done) && flt_bcast && !flt_match && $past(mode[3]) && !$past(mode[2])
      |-> !flt_accept);

  assert_allmc_accepts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_done) && flt_mcast && $past(mode[1]) |-> flt_accept);

  assert_promisc_accepts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_done) && !flt_mcast && $past(mode[2]) |-> flt_accept);

  assert_rise_after_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_done) |-> $past(da_valid));

  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid && da_start |=> !flt_done);

  assert_verdict_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flt_done && !(da_valid && da_start)
      |=> flt_done && $stable({flt_accept, flt_bcast, flt_mcast, flt_match}));
endmodule

bind dst_addr_filter dfl_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .da_valid   (da_valid),
  .da_start   (da_start),
  .flt_done   (flt_done),
  .flt_accept (flt_accept),
  .flt_bcast  (flt_bcast),
  .flt_mcast  (flt_mcast),
  .flt_match  (flt_match)
);

// File: tb/sim_dst_addr_filter.sv
`timescale 1ns/1ps
module sim_dst_addr_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_idx = '0;
  logic [7:0] cfg_wdata = '0;
  logic [3:0] mode = '0;
  logic       hash_hit = 1'b0;
  logic       da_valid = 1'b0;
  logic       da_start = 1'b0;
  logic [7:0] da_byte = '0;
  logic       flt_done, flt_accept, flt_bcast, flt_mcast, flt_match;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  dst_addr_filter u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .mode(mode), .hash_hit(hash_hit),
    .da_valid(da_valid), .da_start(da_start), .da_byte(da_byte),
    .flt_done(flt_done), .flt_accept(flt_accept), .flt_bcast(flt_bcast),
    .flt_mcast(flt_mcast), .flt_match(flt_match)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0] m_mem [0:59];
  logic [7:0] q [$];
  bit m_busy, m_done, m_acc, m_bc, m_mc, m_match;

  task automatic m_eval();
    bit bc, mc, hit, any;
    bc = 1;
    for (int i = 0; i < 6; i++) if (q[i] != 8'hFF) bc = 0;
    mc = q[0][0] && !bc;
    any = 0;
    for (int e = 0; e < 10; e++) begin
      hit = (e == 0) || mode[0];
      for (int i = 0; i < 6; i++) if (m_mem[e*6+i] != q[i]) hit = 0;
      if (hit) any = 1;
    end
    m_match = any;
    m_bc = bc;
    m_mc = mc;
    m_acc = any || (bc && !mode[3]) || (mc && (mode[1] || hash_hit)) || (!mc && mode[2]);
    m_done = 1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 60; i++) m_mem[i] = 8'h00;
      q.delete();
      m_busy = 0; m_done = 0; m_acc = 0; m_bc = 0; m_mc = 0; m_match = 0;
    end else begin
      if (da_valid && da_start) begin
        q.delete(); q.push_back(da_byte);
        m_busy = 1; m_done = 0; m_acc = 0; m_bc = 0; m_mc = 0; m_match = 0;
      end else if (da_valid && m_busy) begin
        q.push_back(da_byte);
      end
      if (m_busy && q.size() == 6) begin
        m_eval();
        m_busy = 0;
      end
      if (cfg_we && cfg_idx < 60) m_mem[cfg_idx] = cfg_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if ({flt_done, flt_accept, flt_bcast, flt_mcast, flt_match} !=
          {m_done, m_acc, m_bc, m_mc, m_match}) begin
        n_err++;
        $display("FAIL %s per-cycle model: actual done/acc/bc/mc/match=%b expected=%b",
                 cur_req, {flt_done, flt_accept, flt_bcast, flt_mcast, flt_match},
                 {m_done, m_acc, m_bc, m_mc, m_match});
      end
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_err++;
      $display("FAIL watchdog R8: actual cycles=%0d expected below 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual done/acc/bc/mc/match=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic expect_v(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {flt_done, flt_accept, flt_bcast, flt_mcast, flt_match};
    chk(act == exp, req, act, exp);
  endtask

  function automatic logic [7:0] ent_b(input int e, input int b);
    return 8'(8'h20 + e*6 + b);
  endfunction

  function automatic logic [47:0] ent_addr(input int e);
    logic [47:0] a;
    for (int b = 0; b < 6; b++) a[b*8 +: 8] = ent_b(e, b);
    return a;
  endfunction

  task automatic wr(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // Sends six bytes, byte 0 in a[7:0]; returns at the negedge after the sixth byte.
  task automatic send(input logic [47:0] a, input int gap);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      da_valid = 1; da_start = (i == 0); da_byte = a[i*8 +: 8];
      if (gap > 0 && i < 5) begin
        @(negedge clk);
        da_valid = 0; da_start = 0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    da_valid = 0; da_start = 0;
  endtask

  task automatic raw_byte(input logic [7:0] d);
    @(negedge clk);
    da_valid = 1; da_start = 0; da_byte = d;
    @(negedge clk);
    da_valid = 0;
  endtask

  initial begin
    logic [47:0] a;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    expect_v("R1", 5'b00000);

    for (int e = 0; e < 10; e++)
      for (int b = 0; b < 6; b++) wr(8'(e*6 + b), ent_b(e, b));

    // R2: every entry matches with filtering enabled
    cur_req = "R2";
    mode = 4'b0001;
    for (int e = 0; e < 10; e++) begin
      send(ent_addr(e), 0);
      expect_v("R2", 5'b11001);
    end

    // R4: entry 1 spans the eight-byte page boundary (indices 6..11)
    cur_req = "R4";
    wr(8'd8, 8'h99);
    a = ent_addr(1); a[2*8 +: 8] = 8'h99;
    send(a, 0);
    expect_v("R4", 5'b11001);
    send(ent_addr(1), 0);
    expect_v("R4", 5'b10000);
    wr(8'd8, ent_b(1, 2));
    wr(8'd60, 8'h55);
    wr(8'd255, 8'h21);
    send(ent_addr(9), 0);
    expect_v("R4", 5'b11001);
    send(ent_addr(0), 0);
    expect_v("R4", 5'b11001);

    // R3: entry 0 always live, others gated
    cur_req = "R3";
    mode = 4'b0000;
    send(ent_addr(0), 0);
    expect_v("R3", 5'b11001);
    send(ent_addr(5), 0);
    expect_v("R3", 5'b10000);

    // R5: broadcast
    cur_req = "R5";
    send(48'hFFFF_FFFF_FFFF, 0);
    expect_v("R5", 5'b11100);
    mode = 4'b1000;
    send(48'hFFFF_FFFF_FFFF, 0);
    expect_v("R5", 5'b10100);

    // R6: multicast
    cur_req = "R6";
    mode = 4'b0000;
    send(48'h3412_005E_0001, 0);
    expect_v("R6", 5'b10010);
    mode = 4'b0010;
    send(48'h3412_005E_0001, 0);
    expect_v("R6", 5'b11010);
    mode = 4'b0000; hash_hit = 1;
    send(48'h3412_005E_0001, 0);
    expect_v("R6", 5'b11010);
    hash_hit = 0;

    // R7: promiscuous covers unicast only
    cur_req = "R7";
    mode = 4'b0100;
    send(48'h0000_0000_7702, 0);
    expect_v("R7", 5'b11000);
    send(48'h0000_0000_7703, 0);
    expect_v("R7", 5'b10010);

    // R8: gaps between bytes, verdict held over idle cycles
    cur_req = "R8";
    mode = 4'b0001;
    send(ent_addr(4), 2);
    expect_v("R8", 5'b11001);
    repeat (4) @(negedge clk);
    expect_v("R8", 5'b11001);

    // R9: extra bytes and bytes with no open frame
    cur_req = "R9";
    raw_byte(8'h00);
    raw_byte(8'hFF);
    expect_v("R9", 5'b11001);
    mode = 4'b0000;
    send(48'h0000_0000_7702, 0);
    expect_v("R9", 5'b10000);
    for (int i = 0; i < 6; i++) raw_byte(ent_b(0, i));
    expect_v("R9", 5'b10000);

    // R10: mode and hash changes after the sixth byte are ignored
    cur_req = "R10";
    mode = 4'b0100;
    send(48'h0000_0000_7702, 0);
    mode = 4'b0000; hash_hit = 1;
    repeat (2) @(negedge clk);
    expect_v("R10", 5'b11000);
    hash_hit = 0;

    // start clears verdict at its edge
    cur_req = "R8";
    @(negedge clk);
    da_valid = 1; da_start = 1; da_byte = 8'h02;
    @(negedge clk);
    da_valid = 0; da_start = 0;
    expect_v("R8", 5'b00000);

    // randomised phase, checked every cycle against the model
    cur_req = "R2";
    for (int f = 0; f < 80; f++) begin
      int kind;
      kind = $urandom_range(0, 4);
      case (kind)
        0: a = ent_addr($urandom_range(0, 9));
        1: a = {$urandom(), 8'($urandom()), 8'($urandom()) & 8'hFE};
        2: a = {$urandom(), 8'($urandom()), 8'($urandom()) | 8'h01};
        3: a = 48'hFFFF_FFFF_FFFF;
        default: a = ent_addr(0);
      endcase
      mode = 4'($urandom());
      hash_hit = 1'($urandom());
      if ($urandom_range(0, 5) == 0) wr(8'($urandom_range(0, 70)), 8'($urandom()));
      send(a, $urandom_range(0, 2));
      if ($urandom_range(0, 3) == 0) raw_byte(8'($urandom()));
    end

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule